// File: doc/BRIEF.md
# Interrupt Acceptance and Vectoring Unit

This unit sits next to a 32-bit processor core and decides, cycle by cycle, whether the core should be diverted to a new program counter. The events it arbitrates are a reset request, one non-maskable interrupt line and six maskable interrupt lines, plus two return signals issued by the core when it leaves a handler. The core presents its current PC and status word every cycle. When the unit accepts an event, it saves context into one of two shadow register pairs, rewrites the status word, updates a cause register and asserts a redirect strobe with the new PC.

The core must act on the redirect in the cycle the strobe is high. It loads `redir_pc` as its PC and `psw_next` as its status word. No handshake back-pressures the unit, so every redirect is final. All outputs are registered: an event sampled at one rising edge appears on the ports right after that edge. Status bit positions are NP = bit 7 (non-maskable service in progress), EP = bit 6 (exception in progress) and ID = bit 5 (maskable interrupts disabled).

Top module: `irq_vector_unit`

## Requirements
- R1: A `reset_req` sampled high gives a strobe with PC 0x0, status 0x20 and cause 0x0, and it discards any held non-maskable request. This applies even when any other input is active in the same cycle.
- R2: An accepted maskable interrupt copies `core_pc` to `irq_save_pc` and `core_psw` to `irq_save_psw`. The new status is the old one with bit 5 set and bit 6 cleared. Cause bits 15:0 take the vector value and bits 31:16 are kept.
- R3: Maskable line i (i = 0..5) has vector 0x80 + 0x10*i, which is also its redirect PC. When several lines are high, the lowest index is taken.
- R4: Maskable lines are level-sensitive and are not taken while status bit 7 or bit 5 is set. A line still high once both bits are clear is taken then, and nothing else changes while it waits.
- R5: A non-maskable request is raised by a 0-to-1 transition of `nmi_in`. On acceptance, `core_pc` goes to `nmi_save_pc` and `core_psw` goes to `nmi_save_psw`. The status sets bits 7 and 5 and clears bit 6, and the PC becomes 0x10.
- R6: On non-maskable acceptance, cause bits 31:16 become zero and bits 15:0 become their old value ORed with 0x10.
- R7: A non-maskable request arriving while status bit 7 is set is held as a single pending request. Any further rising edges in that time merge into it, and it is taken once the bit clears. A level held high after acceptance does not raise a new request.
- R8: A non-maskable request wins over maskable lines in the same cycle. At most one event is accepted per cycle.
- R9: `ret_nmi` redirects to `nmi_save_pc` with status `nmi_save_psw`, and `ret_irq` redirects to `irq_save_pc` with status `irq_save_psw`. Returns rank below reset and above both interrupt kinds, and `ret_nmi` beats `ret_irq`.
- R10: `redir_valid` is high for exactly one cycle per accepted event, right after the edge that sampled it, and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| reset_req | input | 1 | Core reset event request |
| nmi_in | input | 1 | Non-maskable request line, edge-sensitive |
| irq_in | input | 6 | Maskable request lines, level-sensitive |
| core_pc | input | 32 | Current PC of the core |
| core_psw | input | 32 | Current status word of the core |
| ret_nmi | input | 1 | Return from non-maskable handler |
| ret_irq | input | 1 | Return from maskable handler |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | New PC for the core |
| psw_next | output | 32 | New status word for the core |
| nmi_save_pc | output | 32 | PC saved at non-maskable entry |
| nmi_save_psw | output | 32 | Status saved at non-maskable entry |
| irq_save_pc | output | 32 | PC saved at maskable entry |
| irq_save_psw | output | 32 | Status saved at maskable entry |
| cause | output | 32 | Cause register |

## Verification
A wrong pending bit for the non-maskable request shows up as either a missing redirect to 0x10 or a spurious one. This appears in the first cycle status bit 7 is clear, so the bench releases the block after a burst of merged edges and checks that exactly one strobe follows. A wrong arbitration or mask decode shows up at once as a wrong `redir_pc`, or as a strobe while bits 5 or 7 are set. A corrupted shadow or cause register stays hidden until a return is issued or the cause is read, so the bench reads them right after each acceptance and replays both returns.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int PSW_NP_BIT = 7;
  localparam int PSW_EP_BIT = 6;
  localparam int PSW_ID_BIT = 5;

  typedef enum logic [2:0] {
    EV_NONE    = 3'd0,
    EV_RESET   = 3'd1,
    EV_RET_NMI = 3'd2,
    EV_RET_IRQ = 3'd3,
    EV_NMI     = 3'd4,
    EV_IRQ     = 3'd5
  } irqv_event_e;
endpackage

// File: rtl/irqv_nmi_latch.sv
module irqv_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic drop,
  input  logic nmi_in,
  input  logic hold,
  output logic take
);
  logic nmi_q;
  logic pend_q;
  logic rise;
  logic req;

  assign rise = nmi_in & ~nmi_q;
  assign req  = pend_q | rise;
  assign take = req & ~hold & ~drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_in;
      pend_q <= drop ? 1'b0 : (req & ~take);
    end
  end

  AST_NMI_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n) // R7
    (pend_q && hold && !drop) |=> pend_q);
  AST_NMI_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n) // R1
    drop |=> !pend_q);
endmodule

// File: rtl/irqv_irq_arb.sv
module irqv_irq_arb #(
  parameter int NUM_IRQ = 6,
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VEC_BASE = 32'h80,
  parameter logic [XLEN-1:0] VEC_STEP = 32'h10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] req,
  input  logic               enable,
  output logic               take,
  output logic [XLEN-1:0]    vec
);
  logic [NUM_IRQ-1:0] lower_any;
  logic [NUM_IRQ-1:0] grant;

  assign lower_any[0] = 1'b0;
  genvar gi;
  generate
    for (gi = 1; gi < NUM_IRQ; gi++) begin : g_chain
      assign lower_any[gi] = lower_any[gi-1] | req[gi-1];
    end
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_grant
      assign grant[gi] = enable & req[gi] & ~lower_any[gi];
    end
  endgenerate

  always_comb begin
    vec = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (grant[i]) vec = vec | (VEC_BASE + VEC_STEP * XLEN'(i));
    end
  end

  assign take = |grant;

  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) // R3
    $onehot0(grant));
  AST_GRANT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) // R4
    !enable |-> !take);
endmodule

// File: rtl/irqv_ctx_bank.sv
module irqv_ctx_bank #(
  parameter int XLEN = 32,
  parameter logic [XLEN/2-1:0] NMI_CODE = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reset_ev,
  input  logic              nmi_take,
  input  logic              irq_take,
  input  logic [XLEN-1:0]   core_pc,
  input  logic [XLEN-1:0]   core_psw,
  input  logic [XLEN/2-1:0] irq_code,
  output logic [XLEN-1:0]   nmi_save_pc,
  output logic [XLEN-1:0]   nmi_save_psw,
  output logic [XLEN-1:0]   irq_save_pc,
  output logic [XLEN-1:0]   irq_save_psw,
  output logic [XLEN-1:0]   cause
);
  localparam int HALF = XLEN / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_save_pc  <= '0;
      nmi_save_psw <= '0;
      irq_save_pc  <= '0;
      irq_save_psw <= '0;
      cause        <= '0;
    end else if (reset_ev) begin
      cause <= '0;
    end else if (nmi_take) begin
      nmi_save_pc  <= core_pc;
      nmi_save_psw <= core_psw;
      cause        <= {{HALF{1'b0}}, cause[HALF-1:0] | NMI_CODE};
    end else if (irq_take) begin
      irq_save_pc  <= core_pc;
      irq_save_psw <= core_psw;
      cause        <= {cause[XLEN-1:HALF], irq_code};
    end
  end

  AST_CAUSE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) // R1
    reset_ev |=> cause == '0);
  AST_NMI_CAUSE_HALF: assert property (@(posedge clk) disable iff (!rst_n) // R6
    (nmi_take && !reset_ev) |=> (cause[XLEN-1:HALF] == '0) && ((cause[HALF-1:0] & NMI_CODE) == NMI_CODE));
  AST_IRQ_SAVE: assert property (@(posedge clk) disable iff (!rst_n) // R2
    (irq_take && !reset_ev && !nmi_take) |=> irq_save_pc == $past(core_pc));
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NUM_IRQ = 6,
  parameter logic [XLEN-1:0] IRQ_VEC_BASE = 32'h80,
  parameter logic [XLEN-1:0] IRQ_VEC_STEP = 32'h10,
  parameter logic [XLEN-1:0] NMI_VEC = 32'h10,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0,
  parameter logic [XLEN-1:0] RESET_PSW = 32'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reset_req,
  input  logic               nmi_in,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [XLEN-1:0]    core_pc,
  input  logic [XLEN-1:0]    core_psw,
  input  logic               ret_nmi,
  input  logic               ret_irq,
  output logic               redir_valid,
  output logic [XLEN-1:0]    redir_pc,
  output logic [XLEN-1:0]    psw_next,
  output logic [XLEN-1:0]    nmi_save_pc,
  output logic [XLEN-1:0]    nmi_save_psw,
  output logic [XLEN-1:0]    irq_save_pc,
  output logic [XLEN-1:0]    irq_save_psw,
  output logic [XLEN-1:0]    cause
);
  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] ONE  = {{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] NP_M = ONE << PSW_NP_BIT;
  localparam logic [XLEN-1:0] EP_M = ONE << PSW_EP_BIT;
  localparam logic [XLEN-1:0] ID_M = ONE << PSW_ID_BIT;
  localparam logic [HALF-1:0] NMI_CODE = NMI_VEC[HALF-1:0];

  logic        np_set, id_set;
  logic        ret_n_ev, ret_i_ev, above_irq_nmi;
  logic        nmi_take, irq_take, irq_enable;
  logic [XLEN-1:0] irq_vec;
  irqv_event_e ev;

  assign np_set        = (core_psw & NP_M) != '0;
  assign id_set        = (core_psw & ID_M) != '0;
  assign ret_n_ev      = ret_nmi & ~reset_req;
  assign ret_i_ev      = ret_irq & ~reset_req & ~ret_nmi;
  assign above_irq_nmi = reset_req | ret_nmi | ret_irq;

  irqv_nmi_latch u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .drop   (reset_req),
    .nmi_in (nmi_in),
    .hold   (np_set | ret_nmi | ret_irq),
    .take   (nmi_take)
  );

  assign irq_enable = ~np_set & ~id_set & ~above_irq_nmi & ~nmi_take;

  irqv_irq_arb #(
    .NUM_IRQ  (NUM_IRQ),
    .XLEN     (XLEN),
    .VEC_BASE (IRQ_VEC_BASE),
    .VEC_STEP (IRQ_VEC_STEP)
  ) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (irq_in),
    .enable (irq_enable),
    .take   (irq_take),
    .vec    (irq_vec)
  );

  irqv_ctx_bank #(
    .XLEN     (XLEN),
    .NMI_CODE (NMI_CODE)
  ) u_ctx (
    .clk          (clk),
    .rst_n        (rst_n),
    .reset_ev     (reset_req),
    .nmi_take     (nmi_take),
    .irq_take     (irq_take),
    .core_pc      (core_pc),
    .core_psw     (core_psw),
    .irq_code     (irq_vec[HALF-1:0]),
    .nmi_save_pc  (nmi_save_pc),
    .nmi_save_psw (nmi_save_psw),
    .irq_save_pc  (irq_save_pc),
    .irq_save_psw (irq_save_psw),
    .cause        (cause)
  );

  always_comb begin
    if (reset_req)     ev = EV_RESET;
    else if (ret_n_ev) ev = EV_RET_NMI;
    else if (ret_i_ev) ev = EV_RET_IRQ;
    else if (nmi_take) ev = EV_NMI;
    else if (irq_take) ev = EV_IRQ;
    else               ev = EV_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      psw_next    <= '0;
    end else begin
      redir_valid <= (ev != EV_NONE);
      case (ev)
        EV_RESET: begin
          redir_pc <= RESET_PC;
          psw_next <= RESET_PSW;
        end
        EV_RET_NMI: begin
          redir_pc <= nmi_save_pc;
          psw_next <= nmi_save_psw;
        end
        EV_RET_IRQ: begin
          redir_pc <= irq_save_pc;
          psw_next <= irq_save_psw;
        end
        EV_NMI: begin
          redir_pc <= NMI_VEC;
          psw_next <= (core_psw | NP_M | ID_M) & ~EP_M;
        end
        EV_IRQ: begin
          redir_pc <= irq_vec;
          psw_next <= (core_psw | ID_M) & ~EP_M;
        end
        default: begin
          redir_pc <= redir_pc;
          psw_next <= psw_next;
        end
      endcase
    end
  end

  AST_RESET_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n) // R1
    reset_req |=> redir_valid && redir_pc == RESET_PC && psw_next == RESET_PSW);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) // R4
    ((np_set || id_set) && !above_irq_nmi && !nmi_take) |=> !redir_valid);
  AST_NMI_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) // R5
    (nmi_take && !above_irq_nmi) |=> redir_valid && redir_pc == NMI_VEC && (psw_next & NP_M) != '0);
  AST_NMI_OVER_IRQ: assert property (@(posedge clk) disable iff (!rst_n) // R8
    nmi_take |-> !irq_take);
  AST_RET_IRQ_PATH: assert property (@(posedge clk) disable iff (!rst_n) // R9
    (ret_irq && !ret_nmi && !reset_req) |=> redir_valid && redir_pc == $past(irq_save_pc));
  AST_STROBE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n) // R10
    (!reset_req && !ret_nmi && !ret_irq && !nmi_take && !irq_take) |=> !redir_valid);
endmodule

// File: tb/irq_vector_unit_tb_top.sv
module irq_vector_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reset_req = 1'b0;
  logic        nmi_in = 1'b0;
  logic [5:0]  irq_in = '0;
  logic [31:0] core_pc = '0;
  logic [31:0] core_psw = '0;
  logic        ret_nmi = 1'b0;
  logic        ret_irq = 1'b0;
  logic        redir_valid;
  logic [31:0] redir_pc, psw_next, nmi_save_pc, nmi_save_psw;
  logic [31:0] irq_save_pc, irq_save_psw, cause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit          v;
    logic [31:0] pc;
    logic [31:0] psw;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  irq_vector_unit dut_i (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_in(nmi_in),
    .irq_in(irq_in), .core_pc(core_pc), .core_psw(core_psw),
    .ret_nmi(ret_nmi), .ret_irq(ret_irq), .redir_valid(redir_valid),
    .redir_pc(redir_pc), .psw_next(psw_next), .nmi_save_pc(nmi_save_pc),
    .nmi_save_psw(nmi_save_psw), .irq_save_pc(irq_save_pc),
    .irq_save_psw(irq_save_psw), .cause(cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per driven cycle
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk({e.tag, " strobe"}, {31'd0, redir_valid}, {31'd0, e.v});
      if (e.v) begin
        chk({e.tag, " pc"}, redir_pc, e.pc);
        chk({e.tag, " psw"}, psw_next, e.psw);
      end
    end
  end

  // driver: apply one cycle of inputs and queue the expected outcome
  task automatic step(input bit rr, input bit nm, input logic [5:0] iq,
                      input logic [31:0] pc, input logic [31:0] psw,
                      input bit rn, input bit ri, input bit ev,
                      input logic [31:0] epc, input logic [31:0] epsw,
                      input string tag);
    exp_t e;
    @(negedge clk);
    reset_req = rr; nmi_in = nm; irq_in = iq; core_pc = pc;
    core_psw = psw; ret_nmi = rn; ret_irq = ri;
    e.v = ev; e.pc = epc; e.psw = epsw; e.tag = tag;
    exp_q.push_back(e);
    @(posedge clk);
    #4;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10 / R1: state after block reset
    chk("R10 reset strobe", {31'd0, redir_valid}, 32'd0);
    chk("R1 reset cause", cause, 32'h0);
    chk("R1 reset psw_next", psw_next, 32'h0);

    // R3 single line 2 -> 0xA0; R2 context
    step(0, 0, 6'b000100, 32'h1000, 32'h0, 0, 0, 1, 32'hA0, 32'h20, "R3 line2");
    chk("R2 save pc", irq_save_pc, 32'h1000);
    chk("R2 save psw", irq_save_psw, 32'h0);
    chk("R2 cause", cause, 32'hA0);
    step(0, 0, 6'b000000, 32'h1004, 32'h20, 0, 0, 0, 0, 0, "R10 single pulse");

    // R3 lowest index wins; R2 EP cleared
    step(0, 0, 6'b101000, 32'h2000, 32'h40, 0, 0, 1, 32'hB0, 32'h20, "R3 lowest wins");
    chk("R2 cause low half", cause, 32'hB0);

    // R4 masking by ID and NP, then release
    step(0, 0, 6'b000001, 32'h2100, 32'h20, 0, 0, 0, 0, 0, "R4 masked by ID");
    step(0, 0, 6'b000001, 32'h2104, 32'h80, 0, 0, 0, 0, 0, "R4 masked by NP");
    chk("R4 cause untouched", cause, 32'hB0);
    step(0, 0, 6'b000001, 32'h2108, 32'h01, 0, 0, 1, 32'h80, 32'h21, "R4 released");
    chk("R2 save psw after release", irq_save_psw, 32'h01);

    // R5 / R6 NMI entry
    step(0, 1, 6'b000000, 32'h3000, 32'h40, 0, 0, 1, 32'h10, 32'hA0, "R5 nmi entry");
    chk("R5 nmi save pc", nmi_save_pc, 32'h3000);
    chk("R5 nmi save psw", nmi_save_psw, 32'h40);
    chk("R6 nmi cause", cause, 32'h90);

    // R7 held level gives no new request
    step(0, 1, 6'b000000, 32'h3004, 32'h0, 0, 0, 0, 0, 0, "R7 level held");
    step(0, 0, 6'b000000, 32'h3008, 32'h0, 0, 0, 0, 0, 0, "R7 level drop");

    // R7 merged edges while NP set
    step(0, 1, 6'b000000, 32'h3100, 32'h80, 0, 0, 0, 0, 0, "R7 blocked edge1");
    step(0, 0, 6'b000000, 32'h3104, 32'h80, 0, 0, 0, 0, 0, "R7 blocked gap");
    step(0, 1, 6'b000000, 32'h3108, 32'h80, 0, 0, 0, 0, 0, "R7 blocked edge2");
    step(0, 0, 6'b000000, 32'h310C, 32'h80, 0, 0, 0, 0, 0, "R7 blocked gap2");
    step(0, 0, 6'b000000, 32'h4000, 32'h0, 0, 0, 1, 32'h10, 32'hA0, "R7 pending taken");
    chk("R7 save pc", nmi_save_pc, 32'h4000);
    step(0, 0, 6'b000000, 32'h4004, 32'h0, 0, 0, 0, 0, 0, "R7 merged no second");

    // R8 NMI over maskable
    step(0, 1, 6'b000010, 32'h5000, 32'h0, 0, 0, 1, 32'h10, 32'hA0, "R8 nmi wins");
    step(0, 1, 6'b000010, 32'h5100, 32'hA0, 0, 0, 0, 0, 0, "R8 irq masked in nmi");
    step(0, 0, 6'b000010, 32'h5004, 32'h0, 0, 0, 1, 32'h90, 32'h20, "R8 irq after");
    chk("R2 cause keeps upper", cause, 32'h90);

    // R9 returns
    step(0, 0, 6'b000000, 32'h90, 32'h20, 0, 1, 1, 32'h5004, 32'h0, "R9 ret irq");
    step(0, 0, 6'b000000, 32'h10, 32'hA0, 1, 0, 1, 32'h5000, 32'h0, "R9 ret nmi");
    step(0, 0, 6'b000000, 32'h10, 32'hA0, 1, 1, 1, 32'h5000, 32'h0, "R9 ret nmi beats ret irq");
    step(0, 0, 6'b000001, 32'h90, 32'h0, 0, 1, 1, 32'h5004, 32'h0, "R9 ret over irq");
    step(0, 0, 6'b000001, 32'h6000, 32'h0, 0, 0, 1, 32'h80, 32'h20, "R9 irq next");
    chk("R9 irq save after ret", irq_save_pc, 32'h6000);

    // R1 reset request drops pending NMI
    step(0, 1, 6'b000000, 32'h7000, 32'h80, 0, 0, 0, 0, 0, "R1 pend setup");
    step(1, 0, 6'b000000, 32'h7004, 32'h80, 0, 0, 1, 32'h0, 32'h20, "R1 reset req");
    chk("R1 cause cleared", cause, 32'h0);
    step(0, 0, 6'b000000, 32'h0, 32'h0, 0, 0, 0, 0, 0, "R1 pending dropped");

    // R1 reset beats everything in the same cycle
    step(1, 1, 6'b000001, 32'h8000, 32'h0, 1, 1, 1, 32'h0, 32'h20, "R1 reset priority");
    step(0, 0, 6'b000000, 32'h0, 32'h0, 0, 0, 0, 0, 0, "R1 same-cycle nmi dropped");
    chk("R1 cause after priority", cause, 32'h0);

    @(negedge clk);
    finish_run();
  end
endmodule